// File: doc/BRIEF.md
# Multiplexed-Bus Timing Register Interface

This block is the slave end of an 8-bit port on which a host microcontroller sends an address byte and then a data byte over the same wires. A falling edge on the address strobe marks a valid address on the bus. A falling edge on the data strobe marks valid write data. Both strobes arrive without any timing relation to the block clock, so they pass through a synchroniser, and edges are found on the synchronised copies. The address byte has no linear register number. Its bits select a group: mode registers, or timing registers for the acquisition or display side, each split into horizontal and vertical.

Start and stop positions are 9 bits wide. The low eight bits of each value sit in their own register. The ninth bit of every value in a group sits in one shared MSB register, at the bit position equal to the value's index. One display-horizontal register and one acquisition-horizontal register also carry 2-bit fine delays.

An address byte with bit 7 set does not write anything. It arms a single read: in the next address/data cycle the data strobe acts as an active-low read strobe, and the block drives a status byte that holds the current field identification bits. The assembled register contents leave the block as flat vectors that feed the timing generators.

Top module: `mbr_regif`

## Requirements
- R1: After reset, and after any later reset, every register output reads zero and `bus_oe_o` is low.
- R2: An address with bit 7 = 0, bit 6 = 1 and bit 5 = 1 writes mode register 0 (bit 0 = 0) or mode register 1 (bit 0 = 1). Bits 4..1 are ignored.
- R3: The display-vertical group is selected by address bits 7..3 = 01000. Indices 0..5 load the low byte of 9-bit value k. Index 6 loads the shared MSB register, whose bit k is bit 8 of value k. `disp_v_o[9k+8:9k]` holds value k.
- R4: The display-horizontal group is selected by address bits 7..3 = 01001. Indices 0..5 hold the low bytes and index 6 holds the MSBs, with the same layout as R3. Index 7 holds three 2-bit fine delays: fine delay p comes from data bits 2p+1:2p and appears on `disp_fine_o[2p+1:2p]`.
- R5: The acquisition-vertical group is selected by address bits 7..3 = 01010. Indices 0 and 1 hold the low bytes and index 2 holds the MSBs in bits 1:0.
- R6: The acquisition-horizontal group is selected by address bits 7..3 = 01011. Indices 0 and 1 hold two 8-bit clamp positions. Indices 2 and 3 hold the low bytes of write-window values 0 and 1. Index 4 holds, from the LSB upward: the MSBs of values 0 and 1 (bits 1:0), a 2-bit fine delay (bits 3:2) and three flag bits (bits 6:4).
- R7: A data strobe that follows an address with bit 6 = 0 changes no register.
- R8: A write to an unused index in a group (display-vertical 7, acquisition-vertical 3..7, acquisition-horizontal 5..7) changes no register.
- R9: An address with bit 7 set arms a read. While armed, that cycle's data phase writes nothing. In the next address/data cycle, the block drives `bus_o` = {zeros, `field_i`} with `bus_oe_o` high while the data strobe is low, and it writes no register. Once the data strobe rises, the block returns to write mode.
- R10: `bus_oe_o` is low outside the low phase of the data strobe in a read cycle, including during normal writes.
- R11: A register takes the bus value only at the falling edge of the data strobe. If the bus changes while the strobe stays low, the register keeps the value it took at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 8 | Multiplexed address/data bus from the host |
| addr_stb_i | input | 1 | Address strobe, falling edge latches the address |
| data_stb_i | input | 1 | Data strobe, falling edge writes; active-low read strobe in a read cycle |
| field_i | input | 2 | Field identification bits returned by a read |
| bus_o | output | 8 | Read data toward the host |
| bus_oe_o | output | 1 | Bus output enable |
| disp_v_o | output | 54 | Six 9-bit display-vertical values |
| disp_h_o | output | 54 | Six 9-bit display-horizontal values |
| disp_fine_o | output | 6 | Three 2-bit display fine delays |
| acq_v_o | output | 18 | Two 9-bit acquisition-vertical values |
| acq_clamp_o | output | 16 | Two 8-bit clamp positions |
| acq_we_o | output | 18 | Two 9-bit acquisition write-window values |
| acq_fine_o | output | 2 | Acquisition fine delay |
| acq_flags_o | output | 3 | Acquisition configuration flags |
| mode0_o | output | 8 | Mode register 0 |
| mode1_o | output | 8 | Mode register 1 |

## Verification
The decoder is driven with addresses whose bit patterns differ in one selector bit at a time. This separates the mode, acquisition/display and horizontal/vertical choices, and the bench checks that don't-care bits really are ignored. Low-byte and MSB writes are interleaved in both orders, so the tests can tell a correct 9-bit assembly from a wrong MSB bit position or a lost low byte. Writes with operate cleared and writes to unused indices are followed by read-back of the values they could have disturbed. A read cycle whose address would otherwise hit mode register 0 shows whether the one-shot read both drives the status byte and blocks the write. Holding the data strobe low while the bus changes separates edge capture from level capture.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam int BUS_W      = 8;
    localparam int LO_W       = 8;
    localparam int VAL_W      = LO_W + 1;
    localparam int FINE_W     = 2;
    localparam int IDX_W      = 3;

    localparam int DV_N       = 6;
    localparam int DH_N       = 6;
    localparam int DH_FINE_N  = 3;
    localparam int AV_N       = 2;
    localparam int AH_CLAMP_N = 2;
    localparam int AH_WE_N    = 2;
    localparam int AH_FLAG_W  = 3;

    localparam int DV_MSB_IDX  = DV_N;
    localparam int DH_MSB_IDX  = DH_N;
    localparam int DH_FINE_IDX = DH_N + 1;
    localparam int AV_MSB_IDX  = AV_N;
    localparam int AH_WE_BASE  = AH_CLAMP_N;
    localparam int AH_MISC_IDX = AH_CLAMP_N + AH_WE_N;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_MODE,
        GRP_DV,
        GRP_DH,
        GRP_AV,
        GRP_AH
    } grp_e;

    typedef struct packed {
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } sel_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ARMED,
        RD_DRIVE
    } rd_state_e;

    function automatic sel_t decode_addr(input logic [BUS_W-1:0] a);
        sel_t s;
        s.idx = a[IDX_W-1:0];
        if (a[7] || !a[6]) begin
            s.grp = GRP_NONE;
        end else if (a[5]) begin
            s.grp = GRP_MODE;
            s.idx = {{(IDX_W-1){1'b0}}, a[0]};
        end else begin
            case ({a[4], a[3]})
                2'b00:   s.grp = GRP_DV;
                2'b01:   s.grp = GRP_DH;
                2'b10:   s.grp = GRP_AV;
                default: s.grp = GRP_AH;
            endcase
        end
        return s;
    endfunction

    function automatic logic idx_mapped(input sel_t s);
        int i;
        i = int'(s.idx);
        case (s.grp)
            GRP_MODE: return 1'b1;
            GRP_DV:   return i <= DV_MSB_IDX;
            GRP_DH:   return i <= DH_FINE_IDX;
            GRP_AV:   return i <= AV_MSB_IDX;
            GRP_AH:   return i <= AH_MISC_IDX;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mbr_sync.sv
module mbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-1:0], d_i};
        end
    end

    assign lvl_o  = sh[STAGES-1];
    assign fall_o = sh[STAGES] & ~sh[STAGES-1];
    assign rise_o = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/mbr_rdctl.sv
module mbr_rdctl
    import mbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_fall_i,
    input  logic addr_rd_i,
    input  logic data_rise_i,
    input  logic data_lvl_i,
    output logic idle_o,
    output logic active_o,
    output logic oe_o
);
    rd_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
        end else begin
            case (state)
                RD_IDLE:  if (addr_fall_i && addr_rd_i) state <= RD_ARMED;
                RD_ARMED: if (addr_fall_i) state <= RD_DRIVE;
                RD_DRIVE: if (data_rise_i) state <= RD_IDLE;
                default:  state <= RD_IDLE;
            endcase
        end
    end

    assign idle_o   = (state == RD_IDLE);
    assign active_o = (state == RD_DRIVE);
    assign oe_o     = active_o && !data_lvl_i;
endmodule

// File: rtl/mbr_regfile.sv
module mbr_regfile
    import mbr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we_i,
    input  sel_t                            sel_i,
    input  logic [BUS_W-1:0]                wdata_i,
    output logic [DV_N*VAL_W-1:0]           disp_v_o,
    output logic [DH_N*VAL_W-1:0]           disp_h_o,
    output logic [DH_FINE_N*FINE_W-1:0]     disp_fine_o,
    output logic [AV_N*VAL_W-1:0]           acq_v_o,
    output logic [AH_CLAMP_N*LO_W-1:0]      acq_clamp_o,
    output logic [AH_WE_N*VAL_W-1:0]        acq_we_o,
    output logic [FINE_W-1:0]               acq_fine_o,
    output logic [AH_FLAG_W-1:0]            acq_flags_o,
    output logic [LO_W-1:0]                 mode0_o,
    output logic [LO_W-1:0]                 mode1_o
);
    logic [LO_W-1:0]                dv_lo [DV_N];
    logic [DV_N-1:0]                dv_msb;
    logic [LO_W-1:0]                dh_lo [DH_N];
    logic [DH_N-1:0]                dh_msb;
    logic [DH_FINE_N*FINE_W-1:0]    dh_fine;
    logic [LO_W-1:0]                av_lo [AV_N];
    logic [AV_N-1:0]                av_msb;
    logic [LO_W-1:0]                ah_clamp [AH_CLAMP_N];
    logic [LO_W-1:0]                ah_lo [AH_WE_N];
    logic [AH_WE_N-1:0]             ah_msb;
    logic [FINE_W-1:0]              ah_fine;
    logic [AH_FLAG_W-1:0]           ah_flags;
    logic [LO_W-1:0]                mode_q [2];

    logic hit_dv, hit_dh, hit_av, hit_ah, hit_md;
    int   widx;

    assign hit_dv = we_i && (sel_i.grp == GRP_DV);
    assign hit_dh = we_i && (sel_i.grp == GRP_DH);
    assign hit_av = we_i && (sel_i.grp == GRP_AV);
    assign hit_ah = we_i && (sel_i.grp == GRP_AH);
    assign hit_md = we_i && (sel_i.grp == GRP_MODE);
    assign widx   = int'(sel_i.idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DV_N; k++) dv_lo[k] <= '0;
            for (int k = 0; k < DH_N; k++) dh_lo[k] <= '0;
            for (int k = 0; k < AV_N; k++) av_lo[k] <= '0;
            for (int k = 0; k < AH_CLAMP_N; k++) ah_clamp[k] <= '0;
            for (int k = 0; k < AH_WE_N; k++) ah_lo[k] <= '0;
            for (int k = 0; k < 2; k++) mode_q[k] <= '0;
            dv_msb   <= '0;
            dh_msb   <= '0;
            dh_fine  <= '0;
            av_msb   <= '0;
            ah_msb   <= '0;
            ah_fine  <= '0;
            ah_flags <= '0;
        end else begin
            for (int k = 0; k < DV_N; k++)
                if (hit_dv && widx == k) dv_lo[k] <= wdata_i;
            if (hit_dv && widx == DV_MSB_IDX) dv_msb <= wdata_i[DV_N-1:0];

            for (int k = 0; k < DH_N; k++)
                if (hit_dh && widx == k) dh_lo[k] <= wdata_i;
            if (hit_dh && widx == DH_MSB_IDX)  dh_msb  <= wdata_i[DH_N-1:0];
            if (hit_dh && widx == DH_FINE_IDX) dh_fine <= wdata_i[DH_FINE_N*FINE_W-1:0];

            for (int k = 0; k < AV_N; k++)
                if (hit_av && widx == k) av_lo[k] <= wdata_i;
            if (hit_av && widx == AV_MSB_IDX) av_msb <= wdata_i[AV_N-1:0];

            for (int k = 0; k < AH_CLAMP_N; k++)
                if (hit_ah && widx == k) ah_clamp[k] <= wdata_i;
            for (int k = 0; k < AH_WE_N; k++)
                if (hit_ah && widx == AH_WE_BASE + k) ah_lo[k] <= wdata_i;
            if (hit_ah && widx == AH_MISC_IDX) begin
                ah_msb   <= wdata_i[AH_WE_N-1:0];
                ah_fine  <= wdata_i[AH_WE_N +: FINE_W];
                ah_flags <= wdata_i[AH_WE_N+FINE_W +: AH_FLAG_W];
            end

            for (int k = 0; k < 2; k++)
                if (hit_md && widx == k) mode_q[k] <= wdata_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < DV_N; g++) begin : g_dv
            assign disp_v_o[g*VAL_W +: VAL_W] = {dv_msb[g], dv_lo[g]};
        end
        for (g = 0; g < DH_N; g++) begin : g_dh
            assign disp_h_o[g*VAL_W +: VAL_W] = {dh_msb[g], dh_lo[g]};
        end
        for (g = 0; g < AV_N; g++) begin : g_av
            assign acq_v_o[g*VAL_W +: VAL_W] = {av_msb[g], av_lo[g]};
        end
        for (g = 0; g < AH_CLAMP_N; g++) begin : g_cl
            assign acq_clamp_o[g*LO_W +: LO_W] = ah_clamp[g];
        end
        for (g = 0; g < AH_WE_N; g++) begin : g_we
            assign acq_we_o[g*VAL_W +: VAL_W] = {ah_msb[g], ah_lo[g]};
        end
    endgenerate

    assign disp_fine_o = dh_fine;
    assign acq_fine_o  = ah_fine;
    assign acq_flags_o = ah_flags;
    assign mode0_o     = mode_q[0];
    assign mode1_o     = mode_q[1];
endmodule

// File: rtl/mbr_regif.sv
module mbr_regif
    import mbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIELD_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [7:0]                   bus_i,
    input  logic                         addr_stb_i,
    input  logic                         data_stb_i,
    input  logic [FIELD_W-1:0]           field_i,
    output logic [7:0]                   bus_o,
    output logic                         bus_oe_o,
    output logic [53:0]                  disp_v_o,
    output logic [53:0]                  disp_h_o,
    output logic [5:0]                   disp_fine_o,
    output logic [17:0]                  acq_v_o,
    output logic [15:0]                  acq_clamp_o,
    output logic [17:0]                  acq_we_o,
    output logic [1:0]                   acq_fine_o,
    output logic [2:0]                   acq_flags_o,
    output logic [7:0]                   mode0_o,
    output logic [7:0]                   mode1_o
);
    logic             addr_lvl, addr_fall, addr_rise;
    logic             data_lvl, data_fall, data_rise;
    logic [BUS_W-1:0] bus_pipe [SYNC_STAGES];
    logic [BUS_W-1:0] bus_d;
    logic [BUS_W-1:0] addr_q;
    logic [FIELD_W-1:0] fld_q;
    logic             rd_idle, rd_active;
    logic             wr_fall;
    logic             we;
    sel_t             sel;

    mbr_sync #(.STAGES(SYNC_STAGES)) u_sync_addr (
        .clk(clk), .rst(rst), .d_i(addr_stb_i),
        .lvl_o(addr_lvl), .fall_o(addr_fall), .rise_o(addr_rise)
    );

    mbr_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
        .clk(clk), .rst(rst), .d_i(data_stb_i),
        .lvl_o(data_lvl), .fall_o(data_fall), .rise_o(data_rise)
    );

    // Bus delay line matched to the strobe synchroniser depth
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_bus
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) bus_pipe[0] <= '0;
                    else     bus_pipe[0] <= bus_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) bus_pipe[g] <= '0;
                    else     bus_pipe[g] <= bus_pipe[g-1];
                end
            end
        end
    endgenerate
    assign bus_d = bus_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            fld_q  <= '0;
        end else begin
            fld_q <= field_i;
            if (addr_fall) addr_q <= bus_d;
        end
    end

    mbr_rdctl u_rdctl (
        .clk(clk), .rst(rst),
        .addr_fall_i(addr_fall), .addr_rd_i(bus_d[7]),
        .data_rise_i(data_rise), .data_lvl_i(data_lvl),
        .idle_o(rd_idle), .active_o(rd_active), .oe_o(bus_oe_o)
    );

    assign wr_fall = data_fall;
    assign sel     = decode_addr(addr_q);
    assign we      = wr_fall && rd_idle && idx_mapped(sel);

    mbr_regfile u_regs (
        .clk(clk), .rst(rst),
        .we_i(we), .sel_i(sel), .wdata_i(bus_d),
        .disp_v_o(disp_v_o), .disp_h_o(disp_h_o), .disp_fine_o(disp_fine_o),
        .acq_v_o(acq_v_o), .acq_clamp_o(acq_clamp_o), .acq_we_o(acq_we_o),
        .acq_fine_o(acq_fine_o), .acq_flags_o(acq_flags_o),
        .mode0_o(mode0_o), .mode1_o(mode1_o)
    );

    assign bus_o = bus_oe_o ? {{(BUS_W-FIELD_W){1'b0}}, fld_q} : '0;

    logic unused_ok;
    assign unused_ok = addr_lvl ^ addr_rise;
endmodule

// File: rtl/mbr_regif_chk.sv
module mbr_regif_chk #(
    parameter int FIELD_W = 2,
    parameter int SNAP_W  = 187
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_oe,
    input logic [7:0]        bus_out,
    input logic              wr_stb,
    input logic              rd_idle,
    input logic              rd_active,
    input logic [7:0]        addr_q,
    input logic [SNAP_W-1:0] snap
);
    AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> rd_active); // R10

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ((bus_out >> FIELD_W) == 8'd0)); // R9

    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(snap)); // R11

    AST_OPERATE_CLEAR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !addr_q[6]) |=> $stable(snap)); // R7

    AST_READ_CYCLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !rd_idle |=> $stable(snap)); // R9
endmodule

bind mbr_regif mbr_regif_chk #(.FIELD_W(FIELD_W), .SNAP_W(187)) u_chk (
    .clk(clk), .rst(rst),
    .bus_oe(bus_oe_o), .bus_out(bus_o),
    .wr_stb(wr_fall), .rd_idle(rd_idle), .rd_active(rd_active),
    .addr_q(addr_q),
    .snap({disp_v_o, disp_h_o, disp_fine_o, acq_v_o, acq_clamp_o,
           acq_we_o, acq_fine_o, acq_flags_o, mode0_o, mode1_o})
);

// File: tb/mbr_regif_bench.sv
module mbr_regif_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_i;
    logic        addr_stb, data_stb;
    logic [1:0]  field;
    logic [7:0]  bus_o;
    logic        bus_oe;
    logic [53:0] disp_v, disp_h;
    logic [5:0]  disp_fine;
    logic [17:0] acq_v, acq_we;
    logic [15:0] acq_clamp;
    logic [1:0]  acq_fine;
    logic [2:0]  acq_flags;
    logic [7:0]  mode0, mode1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mbr_regif u_mbr_regif (
        .clk(clk), .rst(rst), .bus_i(bus_i),
        .addr_stb_i(addr_stb), .data_stb_i(data_stb), .field_i(field),
        .bus_o(bus_o), .bus_oe_o(bus_oe),
        .disp_v_o(disp_v), .disp_h_o(disp_h), .disp_fine_o(disp_fine),
        .acq_v_o(acq_v), .acq_clamp_o(acq_clamp), .acq_we_o(acq_we),
        .acq_fine_o(acq_fine), .acq_flags_o(acq_flags),
        .mode0_o(mode0), .mode1_o(mode1)
    );

    // sel: high nibble picks the output, low nibble the index
    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] sel;
        logic [8:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'h40, 8'hA5, 8'h20, 9'h0A5},  // R3 low byte
        '{8'h46, 8'h01, 8'h20, 9'h1A5},  // R3 msb bit 0
        '{8'h45, 8'h3C, 8'h25, 9'h03C},  // R3 low byte idx 5
        '{8'h46, 8'h20, 8'h25, 9'h13C},  // R3 msb bit 5
        '{8'h06, 8'hFF, 8'h20, 9'h0A5},  // R7 operate clear
        '{8'h60, 8'h81, 8'h00, 9'h081},  // R2 mode 0
        '{8'h7F, 8'h42, 8'h10, 9'h042},  // R2 mode 1, don't-care bits set
        '{8'h4B, 8'h77, 8'h33, 9'h077},  // R4 low byte
        '{8'h4E, 8'h08, 8'h33, 9'h177},  // R4 msb bit 3
        '{8'h4F, 8'h1B, 8'h41, 9'h002},  // R4 fine delay 1
        '{8'h51, 8'h33, 8'h51, 9'h033},  // R5 low byte
        '{8'h52, 8'h02, 8'h51, 9'h133},  // R5 msb bit 1
        '{8'h58, 8'h9C, 8'h60, 9'h09C},  // R6 clamp 0
        '{8'h5B, 8'h11, 8'h71, 9'h011},  // R6 window low byte 1
        '{8'h5C, 8'h7E, 8'h71, 9'h111},  // R6 misc msb
        '{8'h5C, 8'h7E, 8'h80, 9'h003},  // R6 fine delay
        '{8'h47, 8'hFF, 8'h25, 9'h13C},  // R8 display-vertical idx 7
        '{8'h55, 8'hFF, 8'h50, 9'h000},  // R8 acquisition-vertical idx 5
        '{8'h5F, 8'hFF, 8'h61, 9'h000}   // R8 acquisition-horizontal idx 7
    };

    function automatic logic [8:0] get_field(input logic [7:0] sel);
        int i;
        i = int'(sel[3:0]);
        case (sel[7:4])
            4'h0:    return {1'b0, mode0};
            4'h1:    return {1'b0, mode1};
            4'h2:    return disp_v[i*9 +: 9];
            4'h3:    return disp_h[i*9 +: 9];
            4'h4:    return {7'b0, disp_fine[i*2 +: 2]};
            4'h5:    return acq_v[i*9 +: 9];
            4'h6:    return {1'b0, acq_clamp[i*8 +: 8]};
            4'h7:    return acq_we[i*9 +: 9];
            4'h8:    return {7'b0, acq_fine};
            default: return {6'b0, acq_flags};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        @(negedge clk);
        bus_i    = a;
        addr_stb = 1'b0;
        wait_cyc(8);
        addr_stb = 1'b1;
        wait_cyc(4);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        addr_phase(a);
        bus_i    = d;
        data_stb = 1'b0;
        wait_cyc(8);
        data_stb = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        bus_i    = 8'h00;
        addr_stb = 1'b1;
        data_stb = 1'b1;
        field    = 2'b00;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);

        // R1 reset state
        chk("R1 regs", 32'({disp_v, disp_h, disp_fine, acq_v, acq_clamp,
                            acq_we, acq_fine, acq_flags, mode0, mode1} != '0), 32'd0);
        chk("R1 oe", 32'(bus_oe), 32'd0);

        for (int v = 0; v < NV; v++) begin
            bus_write(VEC[v].addr, VEC[v].data);
            chk($sformatf("R2-R8 vector %0d", v), 32'(get_field(VEC[v].sel)), 32'(VEC[v].exp));
        end
        chk("R6 flags", 32'(acq_flags), 32'd7);
        chk("R4 fine 0 and 2", 32'({disp_fine[5:4], disp_fine[1:0]}), 32'h7);

        // R11: edge capture, later bus change ignored; R10 no drive in a write
        addr_phase(8'h61);
        bus_i    = 8'h11;
        data_stb = 1'b0;
        wait_cyc(8);
        chk("R10 oe low in write", 32'(bus_oe), 32'd0);
        bus_i = 8'h99;
        wait_cyc(8);
        data_stb = 1'b1;
        wait_cyc(6);
        chk("R11 edge capture", 32'(mode1), 32'h11);

        // R9 one-shot read
        field = 2'b10;
        bus_write(8'h80, 8'h55);
        chk("R9 armed data phase writes nothing", 32'(mode0), 32'h81);
        addr_phase(8'h60);
        bus_i    = 8'hEE;
        data_stb = 1'b0;
        wait_cyc(8);
        chk("R9 oe in read", 32'(bus_oe), 32'd1);
        chk("R9 status byte", 32'(bus_o), 32'h02);
        data_stb = 1'b1;
        wait_cyc(6);
        chk("R10 oe after read", 32'(bus_oe), 32'd0);
        chk("R9 read cycle writes nothing", 32'(mode0), 32'h81);
        bus_write(8'h61, 8'h0F);
        chk("R9 back to write mode", 32'(mode1), 32'h0F);

        // R1 later reset
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        chk("R1 mode after reset", 32'({mode0, mode1}), 32'd0);
        chk("R1 timing after reset", 32'({disp_v, acq_we} != '0), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule